// File: doc/BRIEF.md
# Prescaled Square Wave Tone Generator

This block generates three square-wave tones for a sound synthesizer. The input clock first passes through a prescaler. Two select pins set its ratio: divide by 16, divide by 1 or divide by 128. Each prescaled tick steps one 10-bit down-counter per channel. When a channel's counter is at zero on a tick, it reloads from that channel's period input and inverts the channel's tone bit. Each output is therefore a plain 0/1 square wave. Its frequency is the clock divided by twice the period times the prescale ratio.

Channel 2 also produces a one-cycle strobe each time its tone bit inverts. A neighbouring noise generator can use this strobe as its shift clock. All state runs on one clock edge and uses a synchronous active-low reset. Attenuation and mixing live elsewhere.

Top module: `sq_tone_gen`

## Requirements
- R1: When sel_i is 2'b00 or 2'b11, the prescaler issues one tick every 16 clocks, so a channel with period P inverts its tone every 16*P clocks.
- R2: Each channel inverts its tone bit only on a tick where its counter is zero. It then reloads period-1. On any other tick the counter decrements. The three channels run independently.
- R3: When sel_i is 2'b01, every clock is a tick, so a channel with period P inverts every P clocks.
- R4: When sel_i is 2'b10, the prescaler issues one tick every 128 clocks, so a channel inverts every 128*P clocks.
- R5: A period of 0 behaves exactly like a period of 1, and the tone inverts on every tick.
- R6: ch2_strobe_o is high for exactly the clock cycles in which tone_o[2] has just changed. In the divide-by-16 and divide-by-128 modes it never stays high for two cycles in a row.
- R7: While rst_ni is low at a clock edge, all tone bits, the strobe, every counter and the prescaler clear. After release, the first tick comes on the DIV-th edge and inverts all three tones.
- R8: A change on a period input does not disturb a count in progress. It takes effect at that channel's next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sel_i | input | 2 | Prescale select: 00/11 div 16, 01 div 1, 10 div 128 |
| period0_i | input | 10 | Half-period of channel 0 in ticks |
| period1_i | input | 10 | Half-period of channel 1 in ticks |
| period2_i | input | 10 | Half-period of channel 2 in ticks |
| tone_o | output | 3 | Square-wave bit of each channel |
| ch2_strobe_o | output | 1 | One-cycle pulse on each channel-2 inversion |

## Verification
The bench measures the gap between inversions in each prescale mode, including select value 11. A prescaler that decoded only 00 as divide-by-16 would run that setting at the wrong rate. A period of zero is driven in both the fast and the standard mode: a counter that wrapped to 1023 would produce a gap about a thousand times too long. A period change is made mid-count, where a design that reloaded at once would cut the current half-cycle short. Reset is applied mid-run, and the strobe width is watched throughout, so a strobe stretched over a whole tick interval, or out of step with tone_o[2], is caught by the reference model compared on every clock.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int PERIOD_W = 10;
  localparam int NUM_CH   = 3;
  localparam int DIV_STD  = 16;
  localparam int DIV_SLOW = 128;

  typedef enum logic [1:0] {
    SEL_STD_A = 2'b00,
    SEL_FAST  = 2'b01,
    SEL_SLOW  = 2'b10,
    SEL_STD_B = 2'b11
  } tg_sel_e;
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int DIV_STD  = tg_pkg::DIV_STD,
  parameter int DIV_SLOW = tg_pkg::DIV_SLOW
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int CW = $clog2(DIV_SLOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (tg_pkg::tg_sel_e'(sel_i))
      tg_pkg::SEL_FAST: lim = '0;
      tg_pkg::SEL_SLOW: lim = CW'(DIV_SLOW - 1);
      default:          lim = CW'(DIV_STD - 1);
    endcase
  end

  // >= so a mode switch to a shorter ratio never stalls
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tg_channel.sv
module tg_channel #(
  parameter int PW = tg_pkg::PERIOD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          tone_o,
  output logic          flip_o
);
  logic [PW-1:0] cnt_q;
  logic          tone_q;

  assign flip_o = tick_i && (cnt_q == '0);
  assign tone_o = tone_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        tone_q <= ~tone_q;
        // period 0 acts as 1
        cnt_q  <= (period_i == '0) ? '0 : period_i - 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_tone_gen.sv
module sq_tone_gen #(
  parameter int PW       = tg_pkg::PERIOD_W,
  parameter int DIV_STD  = tg_pkg::DIV_STD,
  parameter int DIV_SLOW = tg_pkg::DIV_SLOW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic [PW-1:0] period0_i,
  input  logic [PW-1:0] period1_i,
  input  logic [PW-1:0] period2_i,
  output logic [2:0]    tone_o,
  output logic          ch2_strobe_o
);
  localparam int NCH = tg_pkg::NUM_CH;

  logic          pre_tick;
  logic [PW-1:0] per [NCH];
  logic [NCH-1:0] flip;
  logic          strobe_q;

  assign per[0] = period0_i;
  assign per[1] = period1_i;
  assign per[2] = period2_i;

  tg_prescaler #(.DIV_STD(DIV_STD), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .tick_o (pre_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tg_channel #(.PW(PW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (pre_tick),
      .period_i (per[g]),
      .tone_o   (tone_o[g]),
      .flip_o   (flip[g])
    );
  end

  // registered so the pulse lines up with the new tone_o[2] value
  always_ff @(posedge clk_i) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= flip[2];
  end

  assign ch2_strobe_o = strobe_q;
endmodule

// File: rtl/tg_checker.sv
module tg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] sel_i,
  input logic       tick_i,
  input logic [2:0] tone_i,
  input logic       strobe_i
);
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tone_i));

  a_r3_fast_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b01) |-> tick_i);

  a_r6_strobe_on_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i == (tone_i[2] != $past(tone_i[2])));

  a_r6_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && sel_i != 2'b01) |=> !strobe_i);

  a_r7_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (tone_i == 3'b000 && !strobe_i));
endmodule

bind sq_tone_gen tg_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .tick_i   (pre_tick),
  .tone_i   (tone_o),
  .strobe_i (ch2_strobe_o)
);

// File: tb/sim_sq_tone_gen.sv
`timescale 1ns/1ps
module sim_sq_tone_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [9:0] p0 = 10'd3, p1 = 10'd5, p2 = 10'd7;
  logic [2:0] tone;
  logic       strobe;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sq_tone_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel),
    .period0_i(p0), .period1_i(p1), .period2_i(p2),
    .tone_o(tone), .ch2_strobe_o(strobe)
  );

  // behavioural reference
  int m_pre = 0;
  int m_cnt [3] = '{0, 0, 0};
  bit m_tone [3] = '{0, 0, 0};
  bit m_strobe = 0;

  function automatic int div_of(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b10) return 128;
    return 16;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_pre = 0; m_strobe = 0;
      for (int c = 0; c < 3; c++) begin m_cnt[c] = 0; m_tone[c] = 0; end
    end else begin
      bit tk;
      int per;
      tk = (m_pre >= div_of(sel) - 1);
      m_strobe = 0;
      if (tk) begin
        for (int c = 0; c < 3; c++) begin
          per = (c == 0) ? int'(p0) : (c == 1) ? int'(p1) : int'(p2);
          if (m_cnt[c] == 0) begin
            m_tone[c] = !m_tone[c];
            m_cnt[c]  = (per == 0) ? 0 : per - 1;
            if (c == 2) m_strobe = 1;
          end else m_cnt[c]--;
        end
      end
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // R2: cycle-by-cycle model comparison
  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      logic [2:0] mt;
      mt = {m_tone[2], m_tone[1], m_tone[0]};
      chk(tone === mt, "R2 tone vs model", tone, mt);
      chk(strobe === m_strobe, "R6 strobe vs model", strobe, m_strobe);
    end
  end

  task automatic gap(input int c, output longint g);
    logic prev;
    longint t0;
    prev = tone[c];
    do @(negedge clk); while (tone[c] == prev);
    prev = tone[c]; t0 = cyc;
    do @(negedge clk); while (tone[c] == prev);
    g = cyc - t0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tone === 3'b000, "R7 reset tones", tone, 0);
    chk(strobe === 1'b0, "R7 reset strobe", strobe, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    longint g;
    longint t0;
    int st;
    int tg;
    logic prev;
    do_reset();
    // R7: first tick on 16th edge after release, all channels invert
    t0 = cyc;
    do @(negedge clk); while (tone == 3'b000);
    chk(cyc - t0 == 16, "R7 first tick", cyc - t0, 16);
    chk(tone === 3'b111, "R7 all invert", tone, 7);

    // R1 divide by 16
    gap(0, g); chk(g == 48,  "R1 ch0 div16 P3", g, 48);
    gap(1, g); chk(g == 80,  "R1 ch1 div16 P5", g, 80);
    gap(2, g); chk(g == 112, "R2 ch2 div16 P7", g, 112);
    @(negedge clk); sel = 2'b11;
    gap(0, g); gap(0, g); chk(g == 48, "R1 sel11 div16", g, 48);

    // R6 strobe count vs ch2 toggles
    st = 0; tg = 0; prev = tone[2];
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (strobe) st++;
      if (tone[2] != prev) tg++;
      prev = tone[2];
    end
    chk(st == tg && tg > 0, "R6 strobe per toggle", st, tg);

    // R3 no division
    @(negedge clk); sel = 2'b01;
    gap(2, g); gap(2, g); chk(g == 7, "R3 div1 P7", g, 7);
    gap(1, g); chk(g == 5, "R3 div1 P5", g, 5);

    // R5 period 0
    @(negedge clk); p0 = 10'd0;
    gap(0, g); gap(0, g); chk(g == 1, "R5 P0 div1", g, 1);
    @(negedge clk); sel = 2'b00;
    gap(0, g); gap(0, g); chk(g == 16, "R5 P0 div16", g, 16);
    @(negedge clk); p0 = 10'd1;
    gap(0, g); gap(0, g); chk(g == 16, "R5 P1 div16", g, 16);

    // R4 divide by 128
    @(negedge clk); sel = 2'b10; p1 = 10'd2;
    gap(1, g); gap(1, g); chk(g == 256, "R4 div128 P2", g, 256);

    // R8 period change mid-count
    @(negedge clk); sel = 2'b01; p0 = 10'd10;
    gap(0, g); gap(0, g); chk(g == 10, "R8 base P10", g, 10);
    prev = tone[0];
    do @(negedge clk); while (tone[0] == prev);
    t0 = cyc;
    repeat (3) @(negedge clk);
    p0 = 10'd2;
    prev = tone[0];
    do @(negedge clk); while (tone[0] == prev);
    chk(cyc - t0 == 10, "R8 no cut", cyc - t0, 10);
    gap(0, g); chk(g == 2, "R8 new period", g, 2);

    // R7 reset mid-run
    do_reset();
    repeat (40) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule